// File: doc/BRIEF.md
# Half-Word Selectable Multiply-Accumulate Unit

This block is an integer execution unit that takes one decoded multiply request per transfer and returns a 32-bit result. It handles three operations: a plain multiply that keeps the low word of the product, a full-width multiply-accumulate `src1 * src2 + src3`, and a 16×16 multiply-accumulate. In the 16×16 form, the instruction word picks for each source operand which half-word is used and whether that half is sign- or zero-extended. Mixed choices give a signed-by-unsigned product. Upper-half products and division are not handled.

Requests arrive on a valid/ready input channel that carries the 32-bit instruction word and the three source values. The unit computes the result in the same cycle and holds it in an output register. The result leaves on a valid/ready output channel. A new request is accepted when the output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While the consumer stalls, the held result stays on the output and input acceptance stops. An instruction word that matches none of the three operations is still accepted and yields a zero result.

Top module: `hwmac_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A word with opcode bits[6:0]=0110011, bits[14:12]=000 and bits[31:25]=0000001 is a plain multiply. The result is the low 32 bits of `in_src1 * in_src2`, and `in_src3` has no effect on it.
- R3: A word with opcode 1011011, bits[14:12]=000 and bits[31:30]=00 is a full multiply-accumulate. The result is the low 32 bits of `in_src1 * in_src2 + in_src3`.
- R4: A word with opcode 1011011 and bit 14 = 1 is a half-word multiply-accumulate. Bit 13 picks the half of `in_src1` and bit 12 picks the half of `in_src2`: 0 selects bits 15:0 and 1 selects bits 31:16.
- R5: In the half-word form, bit 31 sets the extension of the selected `in_src1` half and bit 30 sets it for `in_src2`. A value of 1 means sign-extend and 0 means zero-extend. The two extended halves are multiplied, the low 32 bits are kept, and `in_src3` is added.
- R6: Any other instruction word is accepted and produces a result of 0. This includes opcode 1011011 with bit 14 = 0 and either bits[31:30] ≠ 00 or bits[14:12] ≠ 000.
- R7: A request accepted on a clock edge (`in_valid && in_ready`) appears on `out_result` with `out_valid` = 1 right after that edge.
- R8: While `out_valid && !out_ready`, `in_ready` is 0 and `out_valid` and `out_result` hold their values.
- R9: Additions in both multiply-accumulate forms wrap modulo 2^32, with no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_insn | input | 32 | Instruction word selecting operation, halves and signs |
| in_src1 | input | 32 | First multiplicand |
| in_src2 | input | 32 | Second multiplicand |
| in_src3 | input | 32 | Accumulate addend |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result |

## Verification
The assertions assume that `out_ready` and the input channel are driven to known values in every cycle after reset. They also assume that a request carries its instruction word and sources in the cycle it is accepted. The sign-fill checks on the prepared operands rely on the decode seeing a stable instruction word in that cycle. The bench changes inputs only on the falling clock edge and keeps every signal at a defined value from time zero. It raises `in_valid` only inside tasks that hold each request until it has been accepted.

// File: rtl/hwmac_pkg.sv
package hwmac_pkg;
  localparam int unsigned INSN_W = 32;

  localparam logic [6:0] OPC_CUSTOM_MAC = 7'b1011011;
  localparam logic [6:0] OPC_INT_REG    = 7'b0110011;
  localparam logic [6:0] F7_MULDIV      = 7'b0000001;

  localparam int unsigned BIT_HALF_FORM = 14;
  localparam int unsigned BIT_HI_A      = 13;
  localparam int unsigned BIT_HI_B      = 12;
  localparam int unsigned BIT_SX_A      = 31;
  localparam int unsigned BIT_SX_B      = 30;

  typedef enum logic [1:0] {
    OP_NONE      = 2'd0,
    OP_MUL       = 2'd1,
    OP_MAC_FULL  = 2'd2,
    OP_MAC_HALF  = 2'd3
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [1:0] hi_sel;
    logic [1:0] sext;
  } mac_ctrl_t;
endpackage

// File: rtl/hwmac_decode.sv
module hwmac_decode
  import hwmac_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output mac_ctrl_t         ctrl
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];
  assign f7  = insn[31:25];

  always_comb begin
    ctrl.kind   = OP_NONE;
    ctrl.hi_sel = {insn[BIT_HI_B], insn[BIT_HI_A]};
    ctrl.sext   = {insn[BIT_SX_B], insn[BIT_SX_A]};
    if (opc == OPC_CUSTOM_MAC) begin
      if (insn[BIT_HALF_FORM]) begin
        ctrl.kind = OP_MAC_HALF;
      end else if (f3 == 3'b000 && insn[31:30] == 2'b00) begin
        ctrl.kind = OP_MAC_FULL;
      end
    end else if (opc == OPC_INT_REG && f3 == 3'b000 && f7 == F7_MULDIV) begin
      ctrl.kind = OP_MUL;
    end
  end
endmodule

// File: rtl/hwmac_operand.sv
module hwmac_operand #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] value,
  input  logic         half_mode,
  input  logic         hi_sel,
  input  logic         sext,
  output logic [W-1:0] prep
);
  localparam int unsigned H = W / 2;

  logic [H-1:0] half;
  logic         fill;

  assign half = hi_sel ? value[W-1:H] : value[H-1:0];
  assign fill = sext & half[H-1];
  assign prep = half_mode ? {{H{fill}}, half} : value;

  // R5: zero-extended half leaves the upper half of the operand clear
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode && !sext) |-> (prep[W-1:H] == '0));

  // R5: sign-extended half copies its top bit across the upper half
  a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode && sext) |->
      ($countones(prep[W-1:H]) == (prep[H-1] ? H : 0)));

  // R4: the chosen half lands unchanged in the low half
  a_r4_half_pick: assert property (@(posedge clk) disable iff (!rst_n)
    half_mode |-> (prep[H-1:0] == (hi_sel ? value[W-1:H] : value[H-1:0])));
endmodule

// File: rtl/hwmac_core.sv
module hwmac_core
  import hwmac_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mac_ctrl_t       ctrl,
  input  logic [XLEN-1:0] src1,
  input  logic [XLEN-1:0] src2,
  input  logic [XLEN-1:0] src3,
  output logic [XLEN-1:0] result
);
  localparam int unsigned NOPS = 2;

  logic [XLEN-1:0] raw  [NOPS];
  logic [XLEN-1:0] prep [NOPS];
  logic            half_mode;
  logic [XLEN-1:0] product;
  logic [XLEN-1:0] addend;

  assign raw[0]    = src1;
  assign raw[1]    = src2;
  assign half_mode = (ctrl.kind == OP_MAC_HALF);

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    hwmac_operand #(.W(XLEN)) u_opnd (
      .clk       (clk),
      .rst_n     (rst_n),
      .value     (raw[g]),
      .half_mode (half_mode),
      .hi_sel    (ctrl.hi_sel[g]),
      .sext      (ctrl.sext[g]),
      .prep      (prep[g])
    );
  end

  // low word of the product is exact for any mix of extensions
  assign product = prep[0] * prep[1];

  always_comb begin
    addend = src3;
    if (ctrl.kind == OP_MUL) addend = '0;
  end

  always_comb begin
    result = product + addend;
    if (ctrl.kind == OP_NONE) result = '0;
  end
endmodule

// File: rtl/hwmac_unit.sv
module hwmac_unit
  import hwmac_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [XLEN-1:0]   in_src1,
  input  logic [XLEN-1:0]   in_src2,
  input  logic [XLEN-1:0]   in_src3,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_result
);
  mac_ctrl_t       ctrl;
  logic [XLEN-1:0] comb_result;
  logic            accept;

  hwmac_decode u_decode (
    .insn (in_insn),
    .ctrl (ctrl)
  );

  hwmac_core #(.XLEN(XLEN)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .src1   (in_src1),
    .src2   (in_src2),
    .src3   (in_src3),
    .result (comb_result)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= comb_result;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  // R1: empty output register on leaving reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R7: an accepted request is presented on the next cycle
  a_r7_accept_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R8: stalled result is held and input is blocked
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  a_r8_stall_block: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !accept);

  // R6: unmatched instruction words give a zero result
  a_r6_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ctrl.kind == OP_NONE) |=> (out_result == '0));
endmodule

// File: tb/test_hwmac_unit.sv
module test_hwmac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [31:0] in_src1 = '0;
  logic [31:0] in_src2 = '0;
  logic [31:0] in_src3 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  localparam logic [31:0] I_MUL  = 32'h0200_0033;
  localparam logic [31:0] I_MACF = 32'h1200_005B;
  localparam logic [31:0] I_HALF = 32'h0000_405B;
  localparam logic [31:0] B_HA   = 32'h0000_2000;
  localparam logic [31:0] B_HB   = 32'h0000_1000;
  localparam logic [31:0] B_SA   = 32'h8000_0000;
  localparam logic [31:0] B_SB   = 32'h4000_0000;

  always #5 clk = ~clk;

  hwmac_unit i_hwmac_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_insn    (in_insn),
    .in_src1    (in_src1),
    .in_src2    (in_src2),
    .in_src3    (in_src3),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one request with out_ready high; result checked right after the edge
  task automatic run_one(input string req, input logic [31:0] insn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn;
    in_src1 = a; in_src2 = b; in_src3 = c;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
    chk(req, out_result, exp);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_mul;
    run_one("R2 small", I_MUL, 32'd7, 32'd6, 32'd99, 32'd42);
    run_one("R2 low word", I_MUL, 32'h0001_0000, 32'h0001_0000, 32'd5, 32'd0);
    run_one("R2 neg", I_MUL, 32'hFFFF_FFFD, 32'd4, 32'hFFFF_FFFF, 32'hFFFF_FFF4);
  endtask

  task automatic t_mac_full;
    run_one("R3 basic", I_MACF, 32'd1000, 32'd3, 32'd7, 32'd3007);
    run_one("R9 wrap", I_MACF, 32'hFFFF_FFFF, 32'd1, 32'd2, 32'd1);
    run_one("R3 big", I_MACF, 32'h0001_0001, 32'h0001_0001, 32'd0, 32'h0002_0001);
  endtask

  task automatic t_half_select;
    run_one("R4 lo lo", I_HALF, 32'h0009_0003, 32'h0007_0005, 32'd1, 32'd16);
    run_one("R4 hi lo", I_HALF | B_HA, 32'h0009_0003, 32'h0007_0005, 32'd1, 32'd46);
    run_one("R4 lo hi", I_HALF | B_HB, 32'h0009_0003, 32'h0007_0005, 32'd1, 32'd22);
    run_one("R4 hi hi", I_HALF | B_HA | B_HB, 32'h0009_0003, 32'h0007_0005, 32'd0, 32'd63);
  endtask

  task automatic t_sign_modes;
    run_one("R5 zz", I_HALF, 32'h0000_FFFF, 32'h0000_FFFF, 32'd0, 32'hFFFE_0001);
    run_one("R5 ss", I_HALF | B_SA | B_SB, 32'h0000_FFFF, 32'h0000_FFFF, 32'd0, 32'd1);
    run_one("R5 sz", I_HALF | B_SA, 32'h0000_FFFF, 32'h0000_FFFF, 32'd0, 32'hFFFF_0001);
    run_one("R5 zs", I_HALF | B_SB, 32'h0000_0002, 32'hFFFF_8000, 32'd0, 32'hFFFF_0000);
    run_one("R5 hi signed acc", I_HALF | B_SA | B_HA, 32'hFFFF_0003, 32'h0005_0002, 32'd10, 32'd8);
    run_one("R9 half wrap", I_HALF, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'd0);
  endtask

  task automatic t_unsupported;
    run_one("R6 other opcode", 32'h0000_0013, 32'd3, 32'd4, 32'd5, 32'd0);
    run_one("R6 top bits", 32'h4000_005B, 32'd3, 32'd4, 32'd5, 32'd0);
    run_one("R6 funct3", 32'h0000_105B & 32'hFFFF_BFFF, 32'd3, 32'd4, 32'd5, 32'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_insn = I_MUL; in_src1 = 32'd11; in_src2 = 32'd3; in_src3 = 32'd0;
    @(negedge clk);
    chk("R7 stalled valid", {31'b0, out_valid}, 32'd1);
    chk("R7 stalled data", out_result, 32'd33);
    chk("R8 ready low", {31'b0, in_ready}, 32'd0);
    in_insn = I_MACF; in_src1 = 32'd2; in_src2 = 32'd5; in_src3 = 32'd1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 held data", out_result, 32'd33);
    chk("R8 held valid", {31'b0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 next data", out_result, 32'd11);
    @(negedge clk);
    chk("R7 drained", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul();
    t_mac_full();
    t_half_select();
    t_sign_modes();
    t_unsupported();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule